// File: doc/BRIEF.md
# Coalescing Write-Merge Buffer

This block sits between a write-through data cache and the memory network. It gathers processor stores in a small fully associative buffer of line-sized entries. Each entry holds a line address, the data words of that line, and one dirty bit per word. A store to a line that is already resident merges into its entry. A store to any other line takes a free entry. When no entry is free, the block writes back an entry that it picks at random. The write-back carries only the words that were written, so lines that several processors share at word granularity merge correctly in memory.

At a synchronisation point the owner raises a drain request. The block writes every resident entry to memory and then pulses a completion signal. Memory is reached through a plain request/acknowledge port. A request names a line address and carries all data words of the line with a per-word write mask. The request stays up, unchanged, until the cycle in which the acknowledge is seen.

Top module: `wr_coalesce_buf`

## Requirements
- R1: After reset, with no store and no drain pending, `stReady` is 1 and both `memReqValid` and `drainDone` are 0.
- R2: A store whose line address matches a resident entry is accepted in the cycle it is presented, with no memory traffic. It merges into that entry, so the entry's later write-back carries every word stored to the line in a single transaction, each word with its most recent data.
- R3: A store to a non-resident line is accepted in the cycle it is presented when an entry is free. It takes the lowest-numbered free entry and causes no memory traffic.
- R4: A store to a non-resident line while all entries are occupied is held (`stReady` = 0). The block writes back one resident entry chosen by a free-running LFSR, keeps `stReady` at 0 until that write is acknowledged, and then accepts the store.
- R5: Bit i of `memMask` is set exactly for the words i stored to that line since the entry was allocated. Word i is carried in `memData[32*i+31:32*i]`. Memory words whose mask bit is clear stay unchanged, and a write-back never has an all-zero mask.
- R6: After a drain request, all resident entries are written back one at a time in ascending entry order. Because an empty buffer fills from entry 0 upward, this is also allocation order. `drainDone` is then high for exactly one cycle, the buffer is empty, and a later store to a drained line starts a fresh mask.
- R7: A drain of an empty buffer raises `drainDone` no later than the second clock edge after the request and issues no memory request.
- R8: Once `memReqValid` is 1, it and the request's address and mask stay stable until a cycle with `memAck` = 1.
- R9: With the default 16 entries, stores to 16 distinct lines are all accepted without a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stValid | input | 1 | Store presented |
| stReady | output | 1 | Store accepted at this edge when stValid is high |
| stLineAddr | input | LINE_ADDR_W | Line address of the store |
| stWordIdx | input | log2(LINE_WORDS) | Word within the line |
| stData | input | WORD_W | Store data |
| drainReq | input | 1 | Request to empty the buffer (a one-cycle pulse is enough) |
| drainDone | output | 1 | One-cycle pulse when the drain has completed |
| memReqValid | output | 1 | Write-back request to memory |
| memAck | input | 1 | Memory takes the request at this edge |
| memLineAddr | output | LINE_ADDR_W | Line address of the write-back |
| memData | output | LINE_WORDS*WORD_W | All words of the line |
| memMask | output | LINE_WORDS | Per-word write enables (dirty bits) |

## Verification
The hardest situation to reach from the ports is a store that arrives while the buffer is full, together with a slow acknowledge. Only then can the held-ready behaviour and the random victim be seen. The stimulus fills all sixteen entries with distinct lines, presents a seventeenth line, and has the memory model delay its acknowledge by several cycles, so the bench can watch `stReady` stay low while the write-back waits. A random stream over 24 lines then forces many evictions. For each one, the memory model compares the mask and data with a shadow record of the words stored since that line was last written back.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_DRAIN = 2'd2
  } wcbState_e;

  // strobes from control into the entry storage
  typedef struct packed {
    logic wrHit;    // merge store into the matching entry
    logic wrAlloc;  // claim entry and start a fresh mask
    logic inval;    // drop the entry that memory just took
  } wcbStrobe_t;

endpackage

// File: rtl/wcb_datapath.sv
module wcb_datapath
  import wcb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int LINE_WORDS  = 8,
  parameter int WORD_W      = 32,
  parameter int LINE_ADDR_W = 27,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int WIDX_W     = $clog2(LINE_WORDS),
  localparam int LINE_W     = LINE_WORDS * WORD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  wcbStrobe_t             strb,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [IDX_W-1:0]       selIdx,
  input  logic [LINE_ADDR_W-1:0] stLineAddr,
  input  logic [WIDX_W-1:0]      stWordIdx,
  input  logic [WORD_W-1:0]      stData,
  output logic [NUM_ENTRIES-1:0] hitVec,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic [LINE_ADDR_W-1:0] rdLineAddr,
  output logic [LINE_W-1:0]      rdData,
  output logic [LINE_WORDS-1:0]  rdMask
);

  logic [NUM_ENTRIES-1:0] valid;
  logic [LINE_ADDR_W-1:0] tagArr  [NUM_ENTRIES];
  logic [LINE_W-1:0]      dataArr [NUM_ENTRIES];
  logic [LINE_WORDS-1:0]  maskArr [NUM_ENTRIES];
  logic [LINE_WORDS-1:0]  wordOneHot;
  logic                   doWrite;

  assign wordOneHot = LINE_WORDS'(1) << stWordIdx;
  assign doWrite    = strb.wrHit | strb.wrAlloc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tagArr[i]  <= '0;
        dataArr[i] <= '0;
        maskArr[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strb.inval && selIdx == IDX_W'(i)) begin
          valid[i] <= 1'b0;
        end
        if (doWrite && wrIdx == IDX_W'(i)) begin
          valid[i]   <= 1'b1;
          tagArr[i]  <= stLineAddr;
          maskArr[i] <= (strb.wrAlloc ? '0 : maskArr[i]) | wordOneHot;
          dataArr[i][int'(stWordIdx)*WORD_W +: WORD_W] <= stData;
        end
      end
    end
  end

  // one comparator per entry
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gTagCmp
    assign hitVec[g] = valid[g] && (tagArr[g] == stLineAddr);
  end

  assign validVec   = valid;
  assign rdLineAddr = tagArr[selIdx];
  assign rdData     = dataArr[selIdx];
  assign rdMask     = maskArr[selIdx];

endmodule

// File: rtl/wcb_control.sv
module wcb_control
  import wcb_pkg::*;
#(
  parameter int          NUM_ENTRIES = 16,
  parameter int          LFSR_W      = 16,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1,
  parameter logic [15:0] LFSR_TAPS   = 16'hB400,
  localparam int         IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stValid,
  input  logic                   drainReq,
  input  logic                   memAck,
  input  logic [NUM_ENTRIES-1:0] hitVec,
  input  logic [NUM_ENTRIES-1:0] validVec,
  output logic                   stReady,
  output logic                   memReqValid,
  output logic                   drainDone,
  output wcbStrobe_t             strb,
  output logic [IDX_W-1:0]       wrIdx,
  output logic [IDX_W-1:0]       selIdx
);

  wcbState_e         state, nextState;
  logic [LFSR_W-1:0] lfsr;
  logic [IDX_W-1:0]  victimIdx;
  logic [IDX_W-1:0]  hitIdx, freeIdx, lowIdx;
  logic              anyHit, isFull, anyValid, drainPend, drainGo;

  function automatic logic [IDX_W-1:0] firstSet(input logic [NUM_ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
      if (v[k]) r = IDX_W'(k);
    end
    return r;
  endfunction

  assign hitIdx   = firstSet(hitVec);
  assign freeIdx  = firstSet(~validVec);
  assign lowIdx   = firstSet(validVec);
  assign anyHit   = |hitVec;
  assign isFull   = &validVec;
  assign anyValid = |validVec;
  assign drainGo  = drainReq | drainPend;

  always_comb begin
    nextState   = state;
    strb        = '0;
    stReady     = 1'b0;
    memReqValid = 1'b0;
    wrIdx       = hitIdx;
    selIdx      = lowIdx;
    unique case (state)
      ST_IDLE: begin
        if (drainGo) begin
          nextState = ST_DRAIN;
        end else begin
          stReady = anyHit | ~isFull;
          if (stValid) begin
            if (anyHit) begin
              strb.wrHit = 1'b1;
            end else if (!isFull) begin
              strb.wrAlloc = 1'b1;
              wrIdx        = freeIdx;
            end else begin
              nextState = ST_EVICT;
            end
          end
        end
      end
      ST_EVICT: begin
        memReqValid = 1'b1;
        selIdx      = victimIdx;
        if (memAck) begin
          strb.inval = 1'b1;
          nextState  = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (anyValid) begin
          memReqValid = 1'b1;
          strb.inval  = memAck;
        end else begin
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lfsr      <= LFSR_SEED[LFSR_W-1:0];
      victimIdx <= '0;
      drainPend <= 1'b0;
      drainDone <= 1'b0;
    end else begin
      state <= nextState;
      lfsr  <= lfsr[0] ? ((lfsr >> 1) ^ LFSR_TAPS[LFSR_W-1:0]) : (lfsr >> 1);
      if (state == ST_IDLE && nextState == ST_EVICT) begin
        victimIdx <= lfsr[IDX_W-1:0];
      end
      if (state == ST_IDLE) drainPend <= 1'b0;
      else if (drainReq)    drainPend <= 1'b1;
      drainDone <= (state == ST_DRAIN) && !anyValid;
    end
  end

endmodule

// File: rtl/wr_coalesce_buf.sv
module wr_coalesce_buf
  import wcb_pkg::*;
#(
  parameter int          NUM_ENTRIES = 16,
  parameter int          LINE_WORDS  = 8,
  parameter int          WORD_W      = 32,
  parameter int          LINE_ADDR_W = 27,
  parameter int          LFSR_W      = 16,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1,
  parameter logic [15:0] LFSR_TAPS   = 16'hB400,
  localparam int         IDX_W       = $clog2(NUM_ENTRIES),
  localparam int         WIDX_W      = $clog2(LINE_WORDS),
  localparam int         LINE_W      = LINE_WORDS * WORD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stValid,
  output logic                   stReady,
  input  logic [LINE_ADDR_W-1:0] stLineAddr,
  input  logic [WIDX_W-1:0]      stWordIdx,
  input  logic [WORD_W-1:0]      stData,
  input  logic                   drainReq,
  output logic                   drainDone,
  output logic                   memReqValid,
  input  logic                   memAck,
  output logic [LINE_ADDR_W-1:0] memLineAddr,
  output logic [LINE_W-1:0]      memData,
  output logic [LINE_WORDS-1:0]  memMask
);

  wcbStrobe_t             strb;
  logic [NUM_ENTRIES-1:0] hitVec, validVec;
  logic [IDX_W-1:0]       wrIdx, selIdx;

  wcb_control #(
    .NUM_ENTRIES(NUM_ENTRIES), .LFSR_W(LFSR_W),
    .LFSR_SEED(LFSR_SEED), .LFSR_TAPS(LFSR_TAPS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .stValid(stValid), .drainReq(drainReq),
    .memAck(memAck), .hitVec(hitVec), .validVec(validVec),
    .stReady(stReady), .memReqValid(memReqValid), .drainDone(drainDone),
    .strb(strb), .wrIdx(wrIdx), .selIdx(selIdx)
  );

  wcb_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .LINE_WORDS(LINE_WORDS),
    .WORD_W(WORD_W), .LINE_ADDR_W(LINE_ADDR_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrIdx(wrIdx), .selIdx(selIdx),
    .stLineAddr(stLineAddr), .stWordIdx(stWordIdx), .stData(stData),
    .hitVec(hitVec), .validVec(validVec), .rdLineAddr(memLineAddr),
    .rdData(memData), .rdMask(memMask)
  );

endmodule

// File: rtl/wcb_checker.sv
module wcb_checker #(
  parameter int NUM_ENTRIES = 16,
  parameter int LINE_WORDS  = 8,
  parameter int LINE_ADDR_W = 27
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   stReady,
  input logic                   memReqValid,
  input logic                   memAck,
  input logic [LINE_ADDR_W-1:0] memLineAddr,
  input logic [LINE_WORDS-1:0]  memMask,
  input logic                   drainDone,
  input logic [NUM_ENTRIES-1:0] validVec
);

  AST_READY_LOW_ON_WB: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |-> !stReady);  // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memAck) |=> memReqValid);  // R8
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memAck) |=> ($stable(memLineAddr) && $stable(memMask)));  // R8
  AST_DIRTY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |-> (memMask != '0));  // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    drainDone |=> !drainDone);  // R6
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    drainDone |-> (validVec == '0));  // R6

endmodule

bind wr_coalesce_buf wcb_checker #(
  .NUM_ENTRIES(NUM_ENTRIES), .LINE_WORDS(LINE_WORDS), .LINE_ADDR_W(LINE_ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .stReady(stReady), .memReqValid(memReqValid),
  .memAck(memAck), .memLineAddr(memLineAddr), .memMask(memMask),
  .drainDone(drainDone), .validVec(validVec)
);

// File: tb/wr_coalesce_buf_tb_top.sv
`timescale 1ns/1ps
module wr_coalesce_buf_tb_top;

  localparam int LA_W = 27;
  localparam int NL   = 64;  // lines modelled in bench memory

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stValid = 1'b0;
  logic          stReady;
  logic [LA_W-1:0] stLineAddr = '0;
  logic [2:0]    stWordIdx = '0;
  logic [31:0]   stData = '0;
  logic          drainReq = 1'b0;
  logic          drainDone;
  logic          memReqValid;
  logic          memAck = 1'b0;
  logic [LA_W-1:0] memLineAddr;
  logic [255:0]  memData;
  logic [7:0]    memMask;

  logic [31:0] benchMem [NL][8];
  logic [31:0] refMem   [NL][8];
  logic [7:0]  pend     [NL];
  int          orderLog [NL];
  int          nWrites = 0;
  logic [7:0]  lastMask = '0;
  int          ackDelay = 0;
  int          nChecks = 0;
  int          nFail = 0;

  always #2 clk = ~clk;  // 250 MHz

  wr_coalesce_buf dut_i (
    .clk(clk), .rst_n(rst_n), .stValid(stValid), .stReady(stReady),
    .stLineAddr(stLineAddr), .stWordIdx(stWordIdx), .stData(stData),
    .drainReq(drainReq), .drainDone(drainDone), .memReqValid(memReqValid),
    .memAck(memAck), .memLineAddr(memLineAddr), .memData(memData),
    .memMask(memMask)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: acknowledges after ackDelay cycles, checks every write-back
  initial begin
    int waitCnt;
    waitCnt = 0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
      end else if (memReqValid) begin
        if (waitCnt >= ackDelay) begin
          int ln;
          ln = int'(memLineAddr[5:0]);
          chk("R5", "write-back line in range", longint'(memLineAddr >> 6), 0);
          chk("R5", "write-back mask equals stored words", memMask, pend[ln]);
          for (int w = 0; w < 8; w++) begin
            if (memMask[w]) begin
              chk("R2", "write-back word data", memData[32*w +: 32], refMem[ln][w]);
              benchMem[ln][w] = memData[32*w +: 32];
            end
          end
          pend[ln] = '0;
          lastMask = memMask;
          orderLog[nWrites % NL] = ln;
          nWrites++;
          memAck = 1'b1;
          waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic doStore(input int line, input int w, input logic [31:0] d, output int waits);
    @(negedge clk);
    stValid = 1'b1;
    stLineAddr = LA_W'(line);
    stWordIdx = 3'(w);
    stData = d;
    #1;
    waits = 0;
    while (!stReady && waits < 2000) begin
      @(negedge clk);
      #1;
      waits++;
    end
    @(posedge clk);
    refMem[line][w] = d;
    pend[line][w] = 1'b1;
    #1 stValid = 1'b0;
  endtask

  task automatic doDrain(output int cyc);
    @(negedge clk);
    drainReq = 1'b1;
    @(negedge clk);
    drainReq = 1'b0;
    cyc = 1;
    while (!drainDone && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic checkAllPendClear(input string req);
    int bad;
    bad = 0;
    for (int l = 0; l < NL; l++) if (pend[l] != 0) bad++;
    chk(req, "lines still dirty after drain", bad, 0);
  endtask

  task automatic checkMemory(input string tag);
    for (int l = 0; l < NL; l++) begin
      int mis;
      mis = 0;
      for (int w = 0; w < 8; w++) if (benchMem[l][w] != refMem[l][w]) mis++;
      chk("R5", tag, mis, 0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "stReady after reset", stReady, 1);
    chk("R1", "memReqValid after reset", memReqValid, 0);
    chk("R1", "drainDone after reset", drainDone, 0);
  endtask

  task automatic t_merge();
    int wt, w0, c;
    w0 = nWrites;
    doStore(3, 1, 32'hA1A1_0001, wt); chk("R3", "alloc wait", wt, 0);
    doStore(3, 5, 32'hB5B5_0005, wt); chk("R2", "merge wait", wt, 0);
    doStore(3, 1, 32'hC1C1_0011, wt); chk("R2", "overwrite wait", wt, 0);
    chk("R2", "no traffic before drain", nWrites - w0, 0);
    doDrain(c);
    chk("R2", "single write-back for merged line", nWrites - w0, 1);
    chk("R2", "merged mask words 1 and 5", lastMask, 8'h22);
    checkAllPendClear("R6");
  endtask

  task automatic t_order();
    int wt, w0, c;
    int lines [4] = '{10, 20, 30, 40};
    w0 = nWrites;
    foreach (lines[i]) doStore(lines[i], i, 32'h0D00_0000 + i, wt);
    doDrain(c);
    chk("R6", "drain write count", nWrites - w0, 4);
    foreach (lines[i]) chk("R6", "drain order", orderLog[(w0 + i) % NL], lines[i]);
    chk("R6", "no request after done", memReqValid, 0);
    @(negedge clk);
    chk("R6", "done is a one-cycle pulse", drainDone, 0);
  endtask

  task automatic t_reuse();
    int wt, w0, c;
    w0 = nWrites;
    doStore(10, 2, 32'hFEED_0002, wt);
    doDrain(c);
    chk("R6", "drained line restarts mask", lastMask, 8'h04);
    chk("R6", "one write for reused line", nWrites - w0, 1);
  endtask

  task automatic t_emptyDrain();
    int w0, c;
    w0 = nWrites;
    doDrain(c);
    chk("R7", "empty drain latency <= 2", (c <= 2) ? 1 : 0, 1);
    chk("R7", "empty drain issues no request", nWrites - w0, 0);
  endtask

  task automatic t_fill();
    int wt, w0, waits, c;
    ackDelay = 4;
    w0 = nWrites;
    for (int l = 0; l < 16; l++) begin
      doStore(l, l % 8, 32'h1100_0000 + l, wt);
      chk("R9", "fill store accepted at once", wt, 0);
    end
    chk("R9", "sixteen lines without write-back", nWrites - w0, 0);
    @(negedge clk);
    stValid = 1'b1; stLineAddr = LA_W'(16); stWordIdx = 3'd6; stData = 32'h1600_0006;
    #1;
    chk("R4", "ready low when full and missing", stReady, 0);
    @(negedge clk); #1;
    chk("R4", "eviction requested", memReqValid, 1);
    chk("R4", "ready held low during eviction", stReady, 0);
    waits = 1;
    while (!stReady && waits < 2000) begin
      @(negedge clk); #1; waits++;
    end
    @(posedge clk);
    refMem[16][6] = 32'h1600_0006;
    pend[16][6] = 1'b1;
    #1 stValid = 1'b0;
    chk("R4", "store waited for acknowledge", (waits >= ackDelay) ? 1 : 0, 1);
    chk("R4", "exactly one eviction", nWrites - w0, 1);
    chk("R4", "victim was a resident line", (orderLog[w0 % NL] < 16) ? 1 : 0, 1);
    doDrain(c);
    chk("R6", "drain after fill writes all", nWrites - w0, 17);
    checkAllPendClear("R6");
    checkMemory("memory after fill");
    ackDelay = 0;
  endtask

  task automatic t_random();
    int wt, c;
    ackDelay = 1;
    for (int n = 0; n < 300; n++) begin
      doStore(int'($urandom_range(0, 23)), int'($urandom_range(0, 7)), $urandom, wt);
    end
    doDrain(c);
    checkAllPendClear("R6");
    checkMemory("memory after random stream");
    ackDelay = 0;
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) begin
      pend[l] = '0;
      orderLog[l] = 0;
      for (int w = 0; w < 8; w++) begin
        benchMem[l][w] = {8'(l), 8'(w), 16'h5A5A};
        refMem[l][w]   = {8'(l), 8'(w), 16'h5A5A};
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_merge();
    t_order();
    t_reuse();
    t_emptyDrain();
    t_fill();
    t_random();
    checkMemory("final memory");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule